// File: doc/BRIEF.md
# Parallel Slice Loader and Per-Bin Response Combiner

This block sits in front of a set of identical response-computing channels. It takes a stream of scene points (each one a range-bin address plus a signed complex amplitude), cuts the stream into one contiguous slice per channel, and writes each slice into that channel's private point store. The store is double-banked. While one bank is being replayed, the other bank collects the scene for the next repetition period.

A repetition trigger, accepted only when the block is idle, swaps the banks. Every channel then replays its slice in parallel into a private per-bin accumulator. A combiner follows, walking the bins in ascending order. For each bin it sums the accumulators of all channels through an adder tree and streams out one complex result per cycle. Each result is read and cleared in the same cycle, so the next period starts from zero. The channel core here is a plain accumulate model: it adds each point's amplitude into the bin the point addresses.

A trigger that arrives while a period is still running is reported as an overrun and otherwise discarded. The run in progress finishes untouched.

Top module: `scene_split_summer`

## Requirements
- R1: After reset, rsp_valid_o, rsp_last_o, done_o and overrun_o are all low. No stream appears until a trigger is accepted.
- R2: After each accepted trigger (and after reset), point number k of the incoming scene goes to channel floor(k / SLICE_LEN), at slot k mod SLICE_LEN. A full scene is NUM_CH*SLICE_LEN points.
- R3: Points loaded while a period is running are held for the next period. They do not change the stream of the period in progress. The next accepted trigger makes them the replayed scene.
- R4: For each bin b, the streamed result equals the signed sum of the real parts, and separately of the imaginary parts, of every point of the replayed scene that addresses bin b. Bins that no point addresses give zero.
- R5: A trigger is sampled at clock edge T0. The result for bin b is visible after edge T0+SLICE_LEN+1+b, with rsp_valid_o high and rsp_bin_o = b. There are exactly NUM_BINS consecutive valid cycles, bins ascend from 0, and rsp_last_o is high only with bin NUM_BINS-1.
- R6: done_o is high for exactly the one cycle after the cycle that carries rsp_last_o.
- R7: A trigger sampled while a period is running (from the edge after acceptance through the edge that registers the last bin) raises overrun_o for one cycle, after the next edge. It does not swap banks, does not restart anything and does not disturb the stream in progress.
- R8: Points beyond the first NUM_CH*SLICE_LEN since the last accepted trigger are dropped and never reach any sum.
- R9: The result is exact for any input. Every slot at full-scale amplitude on one bin gives NUM_CH*SLICE_LEN times that amplitude without wrap. The output width is the amplitude width plus ceil(log2(SLICE_LEN)) plus ceil(log2(NUM_CH)) bits.
- R10: The per-bin accumulators are zero at the start of every period, so a result never contains contributions from an earlier scene.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pt_valid_i | input | 1 | Scene point present this cycle |
| pt_bin_i | input | BIN_W | Range bin addressed by the point |
| pt_re_i | input | AMP_W | Real amplitude, signed |
| pt_im_i | input | AMP_W | Imaginary amplitude, signed |
| prt_trig_i | input | 1 | Repetition-period trigger, one-cycle pulse |
| rsp_valid_o | output | 1 | Merged bin result valid |
| rsp_last_o | output | 1 | Marks the final bin of the stream |
| rsp_bin_o | output | BIN_W | Bin index of the current result |
| rsp_re_o | output | OUT_W | Summed real part, signed |
| rsp_im_o | output | OUT_W | Summed imaginary part, signed |
| done_o | output | 1 | One-cycle pulse after the final bin |
| overrun_o | output | 1 | Trigger arrived while busy |

## Verification
The checker watches the shape of the output stream on every cycle:
- the last flag only accompanies a valid final bin;
- valid results step through bins one at a time starting at zero and end only at the last flag;
- done follows the last bin;
- an overrun always traces back to a trigger.

The values of the sums, the slicing of the scene across channels, the hand-over between the loading and replaying banks, the dropping of surplus points, the exactness at full scale and the clean start of each period can only be shown by the bench. It loads known scenes, overlaps the loading with the previous run, and compares every bin against arithmetic totals.

// File: rtl/ssum_pkg.sv
package ssum_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_MERGE
  } ssum_state_e;
endpackage

// File: rtl/ssum_adder_tree.sv
// Recursive balanced adder tree; every node carries the full output width.
module ssum_adder_tree #(
  parameter int N  = 2,
  parameter int IW = 8,
  parameter int OW = IW + 1
) (
  input  logic [N-1:0][IW-1:0] in_i,
  output logic signed [OW-1:0] sum_o
);
  if (N == 1) begin : g_leaf
    assign sum_o = OW'($signed(in_i[0]));
  end else begin : g_node
    localparam int NL = N / 2;
    localparam int NH = N - NL;
    logic signed [OW-1:0] sum_lo, sum_hi;
    ssum_adder_tree #(.N(NL), .IW(IW), .OW(OW)) u_lo (.in_i(in_i[NL-1:0]), .sum_o(sum_lo));
    ssum_adder_tree #(.N(NH), .IW(IW), .OW(OW)) u_hi (.in_i(in_i[N-1:NL]), .sum_o(sum_hi));
    assign sum_o = sum_lo + sum_hi;
  end
endmodule

// File: rtl/ssum_channel.sv
// One compute lane: two-bank point store, accumulate model, per-bin result store.
module ssum_channel #(
  parameter int SLICE_LEN = 8,
  parameter int NUM_BINS  = 16,
  parameter int AMP_W     = 8,
  localparam int IDX_W = $clog2(SLICE_LEN),
  localparam int BIN_W = $clog2(NUM_BINS),
  localparam int ACC_W = AMP_W + $clog2(SLICE_LEN)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    wr_bank_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  logic [BIN_W-1:0]        wr_bin_i,
  input  logic signed [AMP_W-1:0] wr_re_i,
  input  logic signed [AMP_W-1:0] wr_im_i,
  input  logic                    run_i,
  input  logic                    run_bank_i,
  input  logic [IDX_W-1:0]        run_idx_i,
  input  logic                    rd_en_i,
  input  logic [BIN_W-1:0]        rd_bin_i,
  output logic signed [ACC_W-1:0] rd_re_o,
  output logic signed [ACC_W-1:0] rd_im_o
);
  logic [BIN_W-1:0]        pt_bin [2][SLICE_LEN];
  logic signed [AMP_W-1:0] pt_re  [2][SLICE_LEN];
  logic signed [AMP_W-1:0] pt_im  [2][SLICE_LEN];
  logic signed [ACC_W-1:0] acc_re [NUM_BINS];
  logic signed [ACC_W-1:0] acc_im [NUM_BINS];

  logic [BIN_W-1:0]        cur_bin;
  logic signed [AMP_W-1:0] cur_re, cur_im;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      pt_bin[wr_bank_i][wr_idx_i] <= wr_bin_i;
      pt_re[wr_bank_i][wr_idx_i]  <= wr_re_i;
      pt_im[wr_bank_i][wr_idx_i]  <= wr_im_i;
    end
  end

  assign cur_bin = pt_bin[run_bank_i][run_idx_i];
  assign cur_re  = pt_re[run_bank_i][run_idx_i];
  assign cur_im  = pt_im[run_bank_i][run_idx_i];

  // run and read never overlap: the controller sequences them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BINS; b++) begin
        acc_re[b] <= '0;
        acc_im[b] <= '0;
      end
    end else if (run_i) begin
      acc_re[cur_bin] <= acc_re[cur_bin] + ACC_W'(cur_re);
      acc_im[cur_bin] <= acc_im[cur_bin] + ACC_W'(cur_im);
    end else if (rd_en_i) begin
      acc_re[rd_bin_i] <= '0;
      acc_im[rd_bin_i] <= '0;
    end
  end

  assign rd_re_o = acc_re[rd_bin_i];
  assign rd_im_o = acc_im[rd_bin_i];
endmodule

// File: rtl/scene_split_summer.sv
module scene_split_summer
  import ssum_pkg::*;
#(
  parameter int NUM_CH    = 12,
  parameter int SLICE_LEN = 8,
  parameter int NUM_BINS  = 16,
  parameter int AMP_W     = 8,
  localparam int BIN_W = $clog2(NUM_BINS),
  localparam int ACC_W = AMP_W + $clog2(SLICE_LEN),
  localparam int OUT_W = ACC_W + $clog2(NUM_CH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pt_valid_i,
  input  logic [BIN_W-1:0]        pt_bin_i,
  input  logic signed [AMP_W-1:0] pt_re_i,
  input  logic signed [AMP_W-1:0] pt_im_i,
  input  logic                    prt_trig_i,
  output logic                    rsp_valid_o,
  output logic                    rsp_last_o,
  output logic [BIN_W-1:0]        rsp_bin_o,
  output logic signed [OUT_W-1:0] rsp_re_o,
  output logic signed [OUT_W-1:0] rsp_im_o,
  output logic                    done_o,
  output logic                    overrun_o
);
  localparam int IDX_W = $clog2(SLICE_LEN);
  localparam int CH_W  = $clog2(NUM_CH);

  ssum_state_e      state_q;
  logic             act_bank_q;
  logic [IDX_W-1:0] run_idx_q;
  logic [BIN_W-1:0] mrg_bin_q;

  logic [CH_W-1:0]  ld_ch_q, eff_ch, nxt_ch;
  logic [IDX_W-1:0] ld_idx_q, eff_idx, nxt_idx;
  logic             ld_full_q, eff_full, nxt_full;
  logic             wr_bank, trig_acc, pt_acc;

  logic run_en, rd_en, mrg_end;
  logic fin_q;

  logic [NUM_CH-1:0][ACC_W-1:0] ch_re, ch_im;
  logic signed [OUT_W-1:0]      sum_re, sum_im;

  assign trig_acc = prt_trig_i && (state_q == ST_IDLE);
  assign run_en   = (state_q == ST_RUN);
  assign rd_en    = (state_q == ST_MERGE);
  assign mrg_end  = rd_en && (mrg_bin_q == BIN_W'(NUM_BINS - 1));

  // trigger wins: a point in the same cycle opens the next scene
  always_comb begin
    if (trig_acc) begin
      eff_ch   = '0;
      eff_idx  = '0;
      eff_full = 1'b0;
      wr_bank  = act_bank_q;
    end else begin
      eff_ch   = ld_ch_q;
      eff_idx  = ld_idx_q;
      eff_full = ld_full_q;
      wr_bank  = ~act_bank_q;
    end
    pt_acc   = pt_valid_i && !eff_full;
    nxt_ch   = eff_ch;
    nxt_idx  = eff_idx;
    nxt_full = eff_full;
    if (pt_acc) begin
      if (eff_idx == IDX_W'(SLICE_LEN - 1)) begin
        nxt_idx = '0;
        if (eff_ch == CH_W'(NUM_CH - 1)) nxt_full = 1'b1;
        else nxt_ch = eff_ch + 1'b1;
      end else begin
        nxt_idx = eff_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_ch_q   <= '0;
      ld_idx_q  <= '0;
      ld_full_q <= 1'b0;
    end else begin
      ld_ch_q   <= nxt_ch;
      ld_idx_q  <= nxt_idx;
      ld_full_q <= nxt_full;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      act_bank_q <= 1'b0;
      run_idx_q  <= '0;
      mrg_bin_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (trig_acc) begin
          act_bank_q <= ~act_bank_q;
          run_idx_q  <= '0;
          state_q    <= ST_RUN;
        end
        ST_RUN: begin
          run_idx_q <= run_idx_q + 1'b1;
          if (run_idx_q == IDX_W'(SLICE_LEN - 1)) begin
            mrg_bin_q <= '0;
            state_q   <= ST_MERGE;
          end
        end
        ST_MERGE: begin
          mrg_bin_q <= mrg_bin_q + 1'b1;
          if (mrg_end) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ssum_channel #(
      .SLICE_LEN(SLICE_LEN),
      .NUM_BINS (NUM_BINS),
      .AMP_W    (AMP_W)
    ) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (pt_acc && (eff_ch == CH_W'(c))),
      .wr_bank_i (wr_bank),
      .wr_idx_i  (eff_idx),
      .wr_bin_i  (pt_bin_i),
      .wr_re_i   (pt_re_i),
      .wr_im_i   (pt_im_i),
      .run_i     (run_en),
      .run_bank_i(act_bank_q),
      .run_idx_i (run_idx_q),
      .rd_en_i   (rd_en),
      .rd_bin_i  (mrg_bin_q),
      .rd_re_o   (ch_re[c]),
      .rd_im_o   (ch_im[c])
    );
  end

  ssum_adder_tree #(.N(NUM_CH), .IW(ACC_W), .OW(OUT_W)) u_tree_re (.in_i(ch_re), .sum_o(sum_re));
  ssum_adder_tree #(.N(NUM_CH), .IW(ACC_W), .OW(OUT_W)) u_tree_im (.in_i(ch_im), .sum_o(sum_im));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_last_o  <= 1'b0;
      rsp_bin_o   <= '0;
      rsp_re_o    <= '0;
      rsp_im_o    <= '0;
      fin_q       <= 1'b0;
      done_o      <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      rsp_valid_o <= rd_en;
      rsp_last_o  <= mrg_end;
      rsp_bin_o   <= mrg_bin_q;
      rsp_re_o    <= rd_en ? sum_re : '0;
      rsp_im_o    <= rd_en ? sum_im : '0;
      fin_q       <= mrg_end;
      done_o      <= fin_q;
      overrun_o   <= prt_trig_i && (state_q != ST_IDLE);
    end
  end
endmodule

// File: rtl/ssum_checker.sv
module ssum_checker #(
  parameter int NUM_BINS = 16,
  parameter int BIN_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             prt_trig_i,
  input logic             rsp_valid_o,
  input logic             rsp_last_o,
  input logic [BIN_W-1:0] rsp_bin_o,
  input logic             done_o,
  input logic             overrun_o
);
  a_r5_last_is_final_bin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_last_o |-> (rsp_valid_o && rsp_bin_o == BIN_W'(NUM_BINS - 1)));

  a_r5_bins_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_last_o) |=> (rsp_valid_o && rsp_bin_o == $past(rsp_bin_o) + 1'b1));

  a_r5_start_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> (rsp_bin_o == '0));

  a_r5_end_only_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rsp_valid_o) |-> $past(rsp_last_o));

  a_r6_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_last_o |=> (done_o && !rsp_valid_o));

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_overrun_from_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(prt_trig_i));
endmodule

bind scene_split_summer ssum_checker #(
  .NUM_BINS(NUM_BINS),
  .BIN_W   (BIN_W)
) u_ssum_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .prt_trig_i (prt_trig_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_last_o (rsp_last_o),
  .rsp_bin_o  (rsp_bin_o),
  .done_o     (done_o),
  .overrun_o  (overrun_o)
);

// File: tb/scene_split_summer_tb_top.sv
`timescale 1ns/1ps
module scene_split_summer_tb_top;
  localparam int NCH   = 12;
  localparam int S     = 8;
  localparam int B     = 16;
  localparam int AW    = 8;
  localparam int BW    = 4;
  localparam int OW    = AW + 3 + 4;
  localparam int SCENE = NCH * S;
  localparam int EXTRA = 4;
  localparam int NP    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                 pt_valid = 1'b0;
  logic [BW-1:0]        pt_bin = '0;
  logic signed [AW-1:0] pt_re = '0, pt_im = '0;
  logic                 trig = 1'b0;
  logic                 rsp_valid, rsp_last, done, overrun;
  logic [BW-1:0]        rsp_bin;
  logic signed [OW-1:0] rsp_re, rsp_im;

  scene_split_summer #(.NUM_CH(NCH), .SLICE_LEN(S), .NUM_BINS(B), .AMP_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pt_valid_i(pt_valid), .pt_bin_i(pt_bin),
    .pt_re_i(pt_re), .pt_im_i(pt_im), .prt_trig_i(trig),
    .rsp_valid_o(rsp_valid), .rsp_last_o(rsp_last), .rsp_bin_o(rsp_bin),
    .rsp_re_o(rsp_re), .rsp_im_o(rsp_im), .done_o(done), .overrun_o(overrun)
  );

  int  sbin [NP][SCENE+EXTRA];
  int  sre  [NP][SCENE+EXTRA];
  int  sim  [NP][SCENE+EXTRA];
  int  nload[NP];
  int  n_chk = 0, n_bad = 0;
  bit  finished = 1'b0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic build_scenes();
    logic [31:0] h;
    for (int p = 0; p < NP; p++) begin
      h = 32'h0000_5a17 + 32'(p * 977);
      nload[p] = SCENE + ((p == 3) ? EXTRA : 0);
      for (int k = 0; k < SCENE + EXTRA; k++) begin
        h = h * 32'd1103515245 + 32'd12345;
        if (p == 1) begin          // R9: full-scale positive / negative on the top bin
          sbin[p][k] = B - 1; sre[p][k] = 127; sim[p][k] = -128;
        end else if (p == 2) begin // R9: most negative everywhere on bin 0
          sbin[p][k] = 0; sre[p][k] = -128; sim[p][k] = -128;
        end else if (p == 4) begin
          sbin[p][k] = k % B; sre[p][k] = k - 48; sim[p][k] = 3 - (k % 7);
        end else begin
          sbin[p][k] = int'(h[7:4]) % B;
          sre[p][k]  = int'(h[15:8]) - 128;
          sim[p][k]  = int'(h[23:16]) - 128;
        end
        if (p == 3 && k >= SCENE) begin // R8: surplus points that must be dropped
          sbin[p][k] = 0; sre[p][k] = 100; sim[p][k] = 100;
        end
      end
    end
  endtask

  task automatic load_scene(int p);
    for (int k = 0; k < nload[p]; k++) begin
      @(negedge clk);
      pt_valid = 1'b1;
      pt_bin   = BW'(sbin[p][k]);
      pt_re    = AW'(sre[p][k]);
      pt_im    = AW'(sim[p][k]);
    end
    @(negedge clk);
    pt_valid = 1'b0;
  endtask

  // R2 R3 R4 R5 R6 R7 R10: one period, with an optional stray trigger at cycle ovr_c
  task automatic run_prt(int p, int ovr_c);
    int exp_re[B];
    int exp_im[B];
    int b;
    bit ev;
    for (int i = 0; i < B; i++) begin exp_re[i] = 0; exp_im[i] = 0; end
    for (int k = 0; k < SCENE; k++) begin
      exp_re[sbin[p][k]] += sre[p][k];
      exp_im[sbin[p][k]] += sim[p][k];
    end
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    for (int c = 1; c <= S + B + 2; c++) begin
      @(negedge clk);
      trig = (c == ovr_c);
      ev = (c >= S + 1) && (c <= S + B);
      b  = c - S - 1;
      chk("R5", $sformatf("valid p%0d c%0d", p, c), int'(rsp_valid), int'(ev));
      chk("R5", $sformatf("last p%0d c%0d", p, c), int'(rsp_last), int'(ev && b == B - 1));
      chk("R6", $sformatf("done p%0d c%0d", p, c), int'(done), int'(c == S + B + 1));
      chk("R7", $sformatf("overrun p%0d c%0d", p, c), int'(overrun),
          int'(ovr_c != 0 && c == ovr_c + 1));
      if (ev) begin
        chk("R5", $sformatf("bin p%0d c%0d", p, c), int'(rsp_bin), b);
        chk("R4", $sformatf("re p%0d bin%0d", p, b), int'(rsp_re), exp_re[b]);
        chk("R4", $sformatf("im p%0d bin%0d", p, b), int'(rsp_im), exp_im[b]);
      end
    end
    trig = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R5 watchdog: actual 0 expected 1 (run did not complete)");
      summary();
      $finish;
    end
  end

  initial begin
    build_scenes();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "valid in reset", int'(rsp_valid), 0);
    chk("R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "valid idle", int'(rsp_valid), 0);
    chk("R1", "last idle", int'(rsp_last), 0);
    chk("R1", "overrun idle", int'(overrun), 0);
    chk("R1", "done idle", int'(done), 0);
    load_scene(0);
    // R3 R10: each period overlaps the loading of the next scene
    for (int p = 0; p < NP; p++) begin
      fork
        run_prt(p, (p == 3) ? 3 : ((p == 4) ? S + B - 1 : 0));
        begin
          if (p + 1 < NP) begin
            repeat (2) @(negedge clk);
            load_scene(p + 1);
          end
        end
      join
    end
    // R7: dropped triggers leave nothing pending
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      chk("R7", $sformatf("quiet c%0d", c), int'(rsp_valid), 0);
    end
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule